// File: doc/BRIEF.md
# Guarded Clock Divider with Timed Unlock

This block produces a one-cycle clock enable that fires once every 2^n cycles of the undivided clock, where n is a 4-bit divide code. The code sits in a single 8-bit control register. The register can only be changed through a two-step sequence. First, an arming write opens a short acceptance window. Then a data write inside that window carries the new code. Stray or corrupted writes therefore cannot change the system clock rate by accident.

A boot configuration input picks the code loaded at reset. With it low the clock runs undivided; with it high the block starts at divide-by-eight. Once the window is open, software may write any code regardless of that input. A new ratio is not applied mid-period. It takes over at the end of the divided period in progress, so no shortened enable spacing ever reaches downstream logic.

Top module: `guarded_clkdiv`

## Requirements
- R1: Register layout: bit 7 is the change-enable flag, which reads 1 exactly while the acceptance window is open. Bits 3:0 hold the active divide code. Bits 6:4 always read 0. The stored code never exceeds 8.
- R2: While `rst` is high, the code is set to 0 if `boot_div8` is 0 and to 3 if it is 1, and the window is closed.
- R3: A write of exactly 0x80 opens the window. Readback then shows 0x80 OR the current code.
- R4: A write with bit 7 = 0 on any of the four clock edges following the arming edge loads bits 3:0 as the new code.
- R5: The window closes after one accepted data write, or after four edges with no data write. A data write on the fifth edge is ignored.
- R6: A write with bit 7 = 0 while the window is closed leaves the register unchanged.
- R7: A write with bit 7 = 1 and any of bits 6:0 nonzero is ignored and does not open the window.
- R8: An accepted data write carrying a reserved code (9 to 15) keeps the previous code and still closes the window.
- R9: With code n (0 to 8), `clk_en` pulses once every 2^n cycles. With code 0 it stays high continuously.
- R10: A new code takes effect only at the end of the period in progress: the spacing that ends that period equals the old factor, and later spacings equal the new one.
- R11: With `boot_div8` = 1, any valid code, including 0, can be written through the unlock sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Undivided clock |
| rst | input | 1 | Synchronous reset, active high |
| boot_div8 | input | 1 | Boot configuration: 1 selects divide-by-eight at reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register readback |
| clk_en | output | 1 | Divided clock enable, one cycle wide |

## Verification
The assertions assume that `wr_en` and `wr_data` are stable around the rising edge, and that `boot_div8` changes only while `rst` is high, because the reset code is sampled only during reset. The bench drives every input on the falling edge. It toggles `boot_div8` only inside its reset task, and it holds `wr_en` for exactly one edge per write, so each arming and data write lands on a known edge. The window edges (fourth and fifth cycle) are therefore hit exactly.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  localparam int REG_W  = 8;
  localparam int CODE_W = 4;
  localparam int CE_BIT = 7;
  localparam logic [REG_W-1:0] ARM_WORD = 8'h80;
  localparam logic [CODE_W-1:0] BOOT_SLOW_CODE = 4'd3;

  // Division factor for a divide code: 2 to the power of the code.
  function automatic int unsigned div_factor(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // A code is usable when it does not exceed the largest legal code.
  function automatic logic code_valid(input int unsigned code, input int unsigned max_code);
    return code <= max_code;
  endfunction

  // Code loaded at reset, selected by the boot configuration bit.
  function automatic logic [CODE_W-1:0] reset_code(input logic boot_slow);
    return boot_slow ? BOOT_SLOW_CODE : '0;
  endfunction
endpackage

// File: rtl/gcd_unlock.sv
module gcd_unlock #(
  parameter int WIN_CYCLES = 4,
  parameter int MAX_CODE   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      boot_div8,
  input  logic                      wr_en,
  input  logic [gcd_pkg::REG_W-1:0] wr_data,
  output logic [gcd_pkg::CODE_W-1:0] sel_code,
  output logic                      win_open
);
  import gcd_pkg::*;
  localparam int WIN_W = $clog2(WIN_CYCLES + 1);

  logic [WIN_W-1:0] win_cnt;

  // Named events for the checks below.
  wire arm_hit  = wr_en && (wr_data == ARM_WORD);
  wire data_wr  = wr_en && !wr_data[CE_BIT];
  wire accept   = data_wr && win_open;
  wire code_ok  = code_valid(32'(wr_data[CODE_W-1:0]), MAX_CODE);
  wire bad_arm  = wr_en && wr_data[CE_BIT] && (wr_data[CE_BIT-1:0] != '0);

  assign win_open = (win_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt  <= '0;
      sel_code <= reset_code(boot_div8);
    end else begin
      if (arm_hit)
        win_cnt <= WIN_W'(WIN_CYCLES);
      else if (accept)
        win_cnt <= '0;
      else if (win_open)
        win_cnt <= win_cnt - 1'b1;

      if (accept && code_ok)
        sel_code <= wr_data[CODE_W-1:0];
    end
  end

  // R1
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(sel_code) <= MAX_CODE);
  // R3
  arm_opens_chk: assert property (@(posedge clk) disable iff (rst)
    arm_hit |=> win_open);
  // R4
  win_bound_chk: assert property (@(posedge clk) disable iff (rst)
    32'(win_cnt) <= WIN_CYCLES);
  // R5
  single_use_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !win_open);
  // R6
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !win_open) |=> $stable(sel_code));
  // R7
  bad_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (bad_arm && !win_open) |=> !win_open);
  // R8
  reserved_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !code_ok) |=> $stable(sel_code));
endmodule

// File: rtl/gcd_ratio_cnt.sv
module gcd_ratio_cnt #(
  parameter int MAX_CODE = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       boot_div8,
  input  logic [gcd_pkg::CODE_W-1:0] sel_code,
  output logic                       clk_en
);
  import gcd_pkg::*;
  localparam int CNT_W = (MAX_CODE < 1) ? 1 : MAX_CODE;

  logic [CODE_W-1:0] act_code;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limit;
  logic              tick;

  assign limit  = CNT_W'(div_factor(32'(act_code)) - 32'd1);
  assign tick   = (cnt == limit);
  assign clk_en = tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      act_code <= reset_code(boot_div8);
    end else if (tick) begin
      cnt      <= '0;
      act_code <= sel_code;
    end else begin
      cnt      <= cnt + 1'b1;
    end
  end

  // R10
  boundary_only_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(act_code));
  // R10
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= limit);
  // R9
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && sel_code != '0) |=> !tick);
endmodule

// File: rtl/guarded_clkdiv.sv
module guarded_clkdiv #(
  parameter int WIN_CYCLES = 4,
  parameter int MAX_CODE   = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       boot_div8,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       clk_en
);
  import gcd_pkg::*;
  localparam int PAD_W = REG_W - 1 - CODE_W;

  logic [CODE_W-1:0] sel_code;
  logic              win_open;

  gcd_unlock #(.WIN_CYCLES(WIN_CYCLES), .MAX_CODE(MAX_CODE)) u_unlock (
    .clk       (clk),
    .rst       (rst),
    .boot_div8 (boot_div8),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .sel_code  (sel_code),
    .win_open  (win_open)
  );

  gcd_ratio_cnt #(.MAX_CODE(MAX_CODE)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .boot_div8 (boot_div8),
    .sel_code  (sel_code),
    .clk_en    (clk_en)
  );

  assign rd_data = {win_open, {PAD_W{1'b0}}, sel_code};

  // R1
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[CE_BIT-1:CODE_W] == '0);
endmodule

// File: tb/tb_guarded_clkdiv.sv
`timescale 1ns/1ps
module tb_guarded_clkdiv;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       boot_div8 = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       clk_en;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  guarded_clkdiv dut (
    .clk(clk), .rst(rst), .boot_div8(boot_div8),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .clk_en(clk_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic boot);
    @(negedge clk);
    rst = 1'b1; boot_div8 = boot; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Spacing in cycles between two consecutive enable pulses.
  task automatic gap(output int g);
    int guard = 0;
    while (!clk_en && guard < 600) begin @(negedge clk); guard++; end
    g = 0;
    do begin @(negedge clk); g++; end while (!clk_en && g < 600);
  endtask

  // Spacing seen once the new ratio has settled.
  task automatic settled_gap(output int g);
    int tmp;
    gap(tmp);
    gap(g);
  endtask

  task automatic t_reset_states;
    int g;
    do_reset(1'b0);
    check("R2 boot0 readback", rd_data, 8'h00);
    gap(g);
    check("R9 code0 spacing", g, 1);
    do_reset(1'b1);
    check("R2 boot1 readback", rd_data, 8'h03);
    gap(g);
    check("R9 code3 spacing", g, 8);
  endtask

  task automatic t_basic_unlock;
    int g;
    wr(8'h80);
    check("R3 armed readback", rd_data, 8'h83);
    wr(8'h05);
    check("R4 value loaded", rd_data, 8'h05);
    settled_gap(g);
    check("R9 code5 spacing", g, 32);
  endtask

  task automatic t_window_edges;
    wr(8'h80);
    idle(3);
    check("R1 flag still set on last cycle", rd_data, 8'h85);
    wr(8'h02);
    check("R4 fourth edge accepted", rd_data, 8'h02);
    wr(8'h80);
    idle(4);
    check("R5 window timed out", rd_data, 8'h02);
    wr(8'h06);
    check("R5 fifth edge ignored", rd_data, 8'h02);
  endtask

  task automatic t_single_use;
    wr(8'h80);
    wr(8'h01);
    wr(8'h07);
    check("R5 second write ignored", rd_data, 8'h01);
  endtask

  task automatic t_locked_and_bad_arm;
    wr(8'h04);
    check("R6 locked write ignored", rd_data, 8'h01);
    wr(8'h81);
    check("R7 bad arm ignored", rd_data, 8'h01);
    wr(8'h04);
    check("R7 no window after bad arm", rd_data, 8'h01);
  endtask

  task automatic t_reserved;
    int g;
    wr(8'h80);
    wr(8'h0C);
    check("R8 reserved keeps code", rd_data, 8'h01);
    settled_gap(g);
    check("R8 spacing unchanged", g, 2);
  endtask

  task automatic t_boot_override;
    int g;
    do_reset(1'b1);
    wr(8'h80);
    wr(8'h00);
    check("R11 code0 after boot1", rd_data, 8'h00);
    settled_gap(g);
    check("R11 undivided spacing", g, 1);
  endtask

  task automatic t_boundary;
    int g = 0;
    int g2;
    do_reset(1'b1);
    while (!clk_en) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h80;
    @(negedge clk); g++;
    wr_data = 8'h01;
    @(negedge clk); g++;
    wr_en = 1'b0; wr_data = 8'h00;
    while (!clk_en && g < 600) begin @(negedge clk); g++; end
    check("R10 period in progress keeps old factor", g, 8);
    gap(g2);
    check("R10 new factor next period", g2, 2);
  endtask

  task automatic t_large_codes;
    int g;
    wr(8'h80); wr(8'h04);
    settled_gap(g);
    check("R9 code4 spacing", g, 16);
    wr(8'h80); wr(8'h08);
    settled_gap(g);
    check("R9 code8 spacing", g, 256);
  endtask

  initial begin
    t_reset_states();
    t_basic_unlock();
    t_window_edges();
    t_single_use();
    t_locked_and_bad_arm();
    t_reserved();
    t_boot_override();
    t_boundary();
    t_large_codes();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule